// File: doc/BRIEF.md
# Receive Jabber Watchdog

This block protects a receive datapath from a transmitter that never stops sending. While carrier is sensed, it counts the bytes of the current frame. When a frame goes past a fixed length limit (2560 bytes by default), the watchdog trips. It then drives its expired flag high and pulls receive-enable low, which cuts off reception.

After carrier goes away, the block counts bit-time ticks and only then lets reception resume. The release delay is either a short or a long number of bit-times (24 or 48 by default), chosen by a select input. A disable input keeps the watchdog from tripping, and it also frees a tripped watchdog at once. A sticky flag records that a trip has happened. A one-cycle clear pulse resets that flag.

The control path is a four-state machine:
- `ST_IDLE`: no carrier, receive enabled.
- `ST_RECV`: carrier present, bytes counted.
- `ST_TRIP`: expired, carrier still present.
- `ST_DRAIN`: expired, carrier gone, release countdown running.

The transitions are:
- IDLE→RECV on carrier.
- RECV→IDLE when carrier drops.
- RECV→TRIP on a byte strobe past the limit with the watchdog enabled.
- TRIP→DRAIN when carrier drops.
- DRAIN→TRIP when carrier returns.
- DRAIN→IDLE when the countdown completes.
- TRIP→IDLE or DRAIN→IDLE when disable is set.

Top module: `rx_jabber_guard`

## Requirements
- R1: After reset, `wd_expired_o` is 0, `rx_enable_o` is 1 and `trip_seen_o` is 0.
- R2: A frame of exactly LIMIT_BYTES byte strobes does not expire. The next strobe in the same carrier period sets `wd_expired_o`=1 and `rx_enable_o`=0 on the following clock edge.
- R3: The byte count restarts at each carrier-on period. Two frames, each within the limit, do not expire even when their sum exceeds it.
- R4: Once expired, the block stays expired for as long as carrier is present, however many bit ticks or byte strobes arrive.
- R5: With `rel_long_i`=0, the watchdog releases on the 24th `bit_tick_i` after carrier drops. After 23 ticks it is still expired.
- R6: With `rel_long_i`=1, the watchdog releases on the 48th `bit_tick_i` after carrier drops. After 47 ticks it is still expired.
- R7: If carrier returns during the release countdown, the block stays expired. The countdown starts again from zero at the next carrier drop.
- R8: While `wd_off_i`=1, no number of byte strobes makes the watchdog expire.
- R9: Setting `wd_off_i`=1 while expired clears `wd_expired_o` and raises `rx_enable_o` on the next clock edge.
- R10: `trip_seen_o` goes to 1 on the same edge as an expiry and stays 1 after release. A `trip_clr_i` pulse clears it. When a trip and a clear arrive on the same edge, the trip wins.
- R11: Bit ticks received while carrier is still present do not count toward the release delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crs_i | input | 1 | Carrier sense |
| byte_stb_i | input | 1 | One-cycle pulse per received byte |
| bit_tick_i | input | 1 | One-cycle pulse per bit-time |
| rel_long_i | input | 1 | Release select: 0 short delay, 1 long delay |
| wd_off_i | input | 1 | Watchdog disable |
| trip_clr_i | input | 1 | Write-one-to-clear pulse for the sticky flag |
| wd_expired_o | output | 1 | Watchdog expired |
| rx_enable_o | output | 1 | Reception allowed |
| trip_seen_o | output | 1 | Sticky expiry flag |

## Verification
Both flags are decoded from the state register, so every input sampled on one edge shows at the outputs on that same edge. The expiry shows up one clock after the strobe that goes past the limit. The release shows up one clock after the final bit tick. The effect of disable and of the clear pulse also appears one clock later. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads the result exactly one register stage after its stimulus. Release timing is checked on both sides of the boundary: one tick short of the delay, and exactly at it.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_TRIP  = 2'd2,
        ST_DRAIN = 2'd3
    } jab_state_e;
endpackage

// File: rtl/jab_byte_cnt.sv
// Per-frame byte counter, saturating at the limit.
module jab_byte_cnt #(
    parameter int LIMIT = 2560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (inc && cnt != LIM_V)  cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LIM_V);
endmodule

// File: rtl/jab_rel_timer.sv
// Counts bit ticks after carrier loss; done pulses on the final tick.
module jab_rel_timer #(
    parameter int SHORT_TICKS = 24,
    parameter int LONG_TICKS  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic sel_long,
    output logic done
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int W    = $clog2(MAXT + 1);
    localparam logic [W-1:0] SHORT_LAST = W'(SHORT_TICKS - 1);
    localparam logic [W-1:0] LONG_LAST  = W'(LONG_TICKS - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = sel_long ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    assign done = !clr && tick && (cnt == last);
endmodule

// File: rtl/rx_jabber_guard.sv
module rx_jabber_guard #(
    parameter int LIMIT_BYTES = 2560,
    parameter int REL_SHORT   = 24,
    parameter int REL_LONG    = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs_i,
    input  logic byte_stb_i,
    input  logic bit_tick_i,
    input  logic rel_long_i,
    input  logic wd_off_i,
    input  logic trip_clr_i,
    output logic wd_expired_o,
    output logic rx_enable_o,
    output logic trip_seen_o
);
    import jab_pkg::*;

    jab_state_e state, nxt;
    logic at_limit, rel_done, trip_evt;

    jab_byte_cnt #(.LIMIT(LIMIT_BYTES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_IDLE),
        .inc      (byte_stb_i && state == ST_RECV),
        .at_limit (at_limit)
    );

    jab_rel_timer #(.SHORT_TICKS(REL_SHORT), .LONG_TICKS(REL_LONG)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state != ST_DRAIN),
        .tick     (bit_tick_i),
        .sel_long (rel_long_i),
        .done     (rel_done)
    );

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (crs_i) nxt = ST_RECV;
            ST_RECV: begin
                if (!crs_i)                                   nxt = ST_IDLE;
                else if (byte_stb_i && at_limit && !wd_off_i) nxt = ST_TRIP;
            end
            ST_TRIP: begin
                if (wd_off_i)    nxt = ST_IDLE;
                else if (!crs_i) nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wd_off_i)      nxt = ST_IDLE;
                else if (crs_i)    nxt = ST_TRIP;
                else if (rel_done) nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        wd_expired_o = 1'b0;
        rx_enable_o  = 1'b1;
        unique case (state)
            ST_IDLE, ST_RECV: begin
                wd_expired_o = 1'b0;
                rx_enable_o  = 1'b1;
            end
            ST_TRIP, ST_DRAIN: begin
                wd_expired_o = 1'b1;
                rx_enable_o  = 1'b0;
            end
        endcase
    end

    // Sticky expiry flag; a new trip beats a clear
    assign trip_evt = (state == ST_RECV) && (nxt == ST_TRIP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          trip_seen_o <= 1'b0;
        else if (trip_evt)   trip_seen_o <= 1'b1;
        else if (trip_clr_i) trip_seen_o <= 1'b0;
    end
endmodule

// File: rtl/jab_guard_chk.sv
module jab_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic crs_i,
    input logic byte_stb_i,
    input logic bit_tick_i,
    input logic wd_off_i,
    input logic trip_clr_i,
    input logic wd_expired_o,
    input logic rx_enable_o,
    input logic trip_seen_o
);
    // R2: an expiry only follows a byte strobe under carrier
    p_trip_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired_o) |-> $past(byte_stb_i) && $past(crs_i));

    // R4: expired persists while carrier stays and disable is clear
    p_hold_on_carrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expired_o && crs_i && !wd_off_i |=> wd_expired_o);

    // R8: no expiry while disabled
    p_no_trip_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired_o) |-> !$past(wd_off_i));

    // R9: disable frees an expired watchdog next cycle
    p_off_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expired_o && wd_off_i |=> !wd_expired_o && rx_enable_o);

    // R5: release needs disable or a tick without carrier
    p_release_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_expired_o) |-> $past(wd_off_i) || ($past(bit_tick_i) && !$past(crs_i)));

    // R10: sticky flag raised with expiry and held until cleared
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired_o) |-> trip_seen_o);
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_seen_o && !trip_clr_i |=> trip_seen_o);
endmodule

bind rx_jabber_guard jab_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .crs_i        (crs_i),
    .byte_stb_i   (byte_stb_i),
    .bit_tick_i   (bit_tick_i),
    .wd_off_i     (wd_off_i),
    .trip_clr_i   (trip_clr_i),
    .wd_expired_o (wd_expired_o),
    .rx_enable_o  (rx_enable_o),
    .trip_seen_o  (trip_seen_o)
);

// File: tb/sim_rx_jabber_guard.sv
`timescale 1ns/1ps
module sim_rx_jabber_guard;
    localparam int LIMIT = 2560;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crs_i = 1'b0, byte_stb_i = 1'b0, bit_tick_i = 1'b0;
    logic rel_long_i = 1'b0, wd_off_i = 1'b0, trip_clr_i = 1'b0;
    logic wd_expired_o, rx_enable_o, trip_seen_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_jabber_guard u0 (
        .clk(clk), .rst_n(rst_n), .crs_i(crs_i), .byte_stb_i(byte_stb_i),
        .bit_tick_i(bit_tick_i), .rel_long_i(rel_long_i), .wd_off_i(wd_off_i),
        .trip_clr_i(trip_clr_i), .wd_expired_o(wd_expired_o),
        .rx_enable_o(rx_enable_o), .trip_seen_o(trip_seen_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            byte_stb_i = 1'b1; step();
            byte_stb_i = 1'b0; step();
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick_i = 1'b1; step();
            bit_tick_i = 1'b0; step();
        end
    endtask

    task automatic trip();
        crs_i = 1'b1; step();
        send_bytes(LIMIT + 1);
    endtask

    task automatic t_reset();
        chk("R1 expired", wd_expired_o, 1'b0);
        chk("R1 rx_enable", rx_enable_o, 1'b1);
        chk("R1 sticky", trip_seen_o, 1'b0);
    endtask

    task automatic t_limit_and_short_release();
        crs_i = 1'b1; step();
        send_bytes(LIMIT);
        chk("R2 at limit not expired", wd_expired_o, 1'b0);
        byte_stb_i = 1'b1; step(); byte_stb_i = 1'b0;
        chk("R2 expired after extra byte", wd_expired_o, 1'b1);
        chk("R2 rx_enable low", rx_enable_o, 1'b0);
        chk("R10 sticky set", trip_seen_o, 1'b1);
        step();
        rel_long_i = 1'b0; crs_i = 1'b0; step();
        ticks(23);
        chk("R5 still expired at 23", wd_expired_o, 1'b1);
        ticks(1);
        chk("R5 released at 24", wd_expired_o, 1'b0);
        chk("R5 rx_enable back", rx_enable_o, 1'b1);
        chk("R10 sticky holds", trip_seen_o, 1'b1);
    endtask

    task automatic t_sticky_clear();
        trip_clr_i = 1'b1; step(); trip_clr_i = 1'b0;
        chk("R10 sticky cleared", trip_seen_o, 1'b0);
        trip_clr_i = 1'b1; step(); trip_clr_i = 1'b0;
        chk("R10 clear when low", trip_seen_o, 1'b0);
    endtask

    task automatic t_long_release();
        trip();
        rel_long_i = 1'b1; crs_i = 1'b0; step();
        ticks(47);
        chk("R6 still expired at 47", wd_expired_o, 1'b1);
        ticks(1);
        chk("R6 released at 48", wd_expired_o, 1'b0);
        rel_long_i = 1'b0;
    endtask

    task automatic t_carrier_return();
        trip();
        ticks(30);
        chk("R4 held under carrier", wd_expired_o, 1'b1);
        send_bytes(5);
        chk("R4 held after bytes", wd_expired_o, 1'b1);
        crs_i = 1'b0; step();
        ticks(20);
        crs_i = 1'b1; step();
        chk("R7 carrier back stays expired", wd_expired_o, 1'b1);
        crs_i = 1'b0; step();
        ticks(23);
        chk("R7 R11 countdown restarted", wd_expired_o, 1'b1);
        ticks(1);
        chk("R7 released after full delay", wd_expired_o, 1'b0);
    endtask

    task automatic t_restart_count();
        crs_i = 1'b1; step();
        send_bytes(2000);
        crs_i = 1'b0; step(); step();
        crs_i = 1'b1; step();
        send_bytes(2000);
        chk("R3 count restarts per frame", wd_expired_o, 1'b0);
        crs_i = 1'b0; step();
    endtask

    task automatic t_disable();
        wd_off_i = 1'b1; crs_i = 1'b1; step();
        send_bytes(LIMIT + 10);
        chk("R8 no expiry when disabled", wd_expired_o, 1'b0);
        chk("R8 rx_enable stays", rx_enable_o, 1'b1);
        crs_i = 1'b0; step();
        wd_off_i = 1'b0; step();
    endtask

    task automatic t_disable_release();
        trip();
        chk("R9 expired before disable", wd_expired_o, 1'b1);
        wd_off_i = 1'b1; step();
        chk("R9 disable releases", wd_expired_o, 1'b0);
        chk("R9 rx_enable restored", rx_enable_o, 1'b1);
        crs_i = 1'b0; step();
        wd_off_i = 1'b0; step();
    endtask

    task automatic t_trip_beats_clear();
        trip_clr_i = 1'b1; step(); trip_clr_i = 1'b0;
        crs_i = 1'b1; step();
        send_bytes(LIMIT);
        byte_stb_i = 1'b1; trip_clr_i = 1'b1; step();
        byte_stb_i = 1'b0; trip_clr_i = 1'b0;
        chk("R10 trip wins over clear", trip_seen_o, 1'b1);
        wd_off_i = 1'b1; crs_i = 1'b0; step();
        wd_off_i = 1'b0; step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_limit_and_short_release();
        t_sticky_clear();
        t_long_release();
        t_carrier_return();
        t_restart_count();
        t_disable();
        t_disable_release();
        t_trip_beats_clear();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule